// File: doc/BRIEF.md
# Watchdog Timer with Reset Routing

This block is a watchdog timer governed by a single byte-wide control and status field that sits in bits 23 to 16 of a 32-bit register word. Software turns the timer on, then restarts it with a kick command before a fixed period runs out. If a kick is missed, the timer raises a sticky time-out flag. Depending on the control settings, the time-out can also fire a reset pulse and can hold a board-fail indicator.

A reset pulse goes to one of two targets. The system-wide target drives both the system reset and the local reset. The local-only target drives just the local reset. The board-fail output is enabled on its own and follows the time-out flag as a level. After a time-out the counter parks at zero, so exactly one pulse comes out until software kicks or disables the timer. The time-out period and the pulse length are parameters.

Top module: `wdog_ctrl_top`

## Requirements
- R1: After reset, every control field and the time-out flag are 0, `reg_rdata` is 0 and all three outputs are low.
- R2: A write (`reg_sel` and `reg_wr` high for one cycle) stores wdata bit 20 (fail enable), bit 19 (system select), bit 18 (reset enable) and bit 16 (run enable). These read back at the same positions. Bits 23 and 22 are command strobes, bit 17 is reserved and bit 21 is read-only, so writes to them are never stored. Bits 23, 22 and 17 always read 0, as does every bit outside 23..16.
- R3: While the run enable is 0, the counter holds and no time-out ever occurs.
- R4: With run enable at 1 and no further kick, the time-out flag (read bit 21) rises on the PERIOD-th rising clock edge after the write edge that enabled the timer or last reloaded the counter.
- R5: A write with bit 22 set reloads the counter to PERIOD, so kicks spaced less than PERIOD cycles apart prevent any time-out.
- R6: The time-out flag stays at 1 until a write with bit 23 set clears it. If a time-out and a clear fall on the same edge, the flag ends at 1.
- R7: With reset enable at 0, a time-out produces no reset pulse on either reset output.
- R8: With reset enable at 1, a time-out drives `loc_rst_o` high for exactly PULSE_LEN cycles, starting right after the time-out edge. `sys_rst_o` is high for the same cycles when system select was 1 at the time-out, and stays low when it was 0.
- R9: `board_fail_o` equals the time-out flag ANDed with the fail enable, as a level.
- R10: After a time-out the counter stays at zero. No further time-out or pulse occurs until a kick or a disabling write.
- R11: Any write with bit 16 at 0 reloads the counter to PERIOD. Enabling again then times out a full PERIOD edges after the enabling write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select for this watchdog word |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_wdata | input | 32 | Write data; the field occupies bits 23..16 |
| reg_rdata | output | 32 | Read data; the field occupies bits 23..16 |
| sys_rst_o | output | 1 | System-wide reset pulse |
| loc_rst_o | output | 1 | Local reset pulse |
| board_fail_o | output | 1 | Board-fail level |

## Verification
The assertions assume that `reg_sel`, `reg_wr` and `reg_wdata` hold known values at every clock edge after reset. They also assume that a write lasts exactly one cycle, because a held write would repeat the kick or clear strobe on every edge. The stimulus meets both assumptions. It changes inputs only one nanosecond after a rising edge, always drives defined values, and opens every write for a single cycle. One write is deliberately timed onto the time-out edge to exercise the set-over-clear rule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int FIELD_LSB = 16;
  localparam int FIELD_W   = 8;
  // bit positions inside the byte field
  localparam int B_CLR  = 7;
  localparam int B_KICK = 6;
  localparam int B_STAT = 5;
  localparam int B_FEN  = 4;
  localparam int B_SSEL = 3;
  localparam int B_RSTE = 2;
  localparam int B_RUN  = 0;

  typedef struct packed {
    logic fail_en;
    logic sys_sel;
    logic rst_en;
    logic run_en;
  } wd_ctrl_t;

  function automatic wd_ctrl_t take_ctrl(input logic [FIELD_W-1:0] b);
    wd_ctrl_t c;
    c.fail_en = b[B_FEN];
    c.sys_sel = b[B_SSEL];
    c.rst_en  = b[B_RSTE];
    c.run_en  = b[B_RUN];
    return c;
  endfunction

  function automatic logic [FIELD_W-1:0] show_field(input wd_ctrl_t c, input logic stat);
    logic [FIELD_W-1:0] b;
    b          = '0;
    b[B_STAT]  = stat;
    b[B_FEN]   = c.fail_en;
    b[B_SSEL]  = c.sys_sel;
    b[B_RSTE]  = c.rst_en;
    b[B_RUN]   = c.run_en;
    return b;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [FIELD_W-1:0] wr_byte,
  input  logic               tmo_evt,
  output wd_ctrl_t           ctrl_q,
  output logic               status_q,
  output logic               reload_evt,
  output logic [FIELD_W-1:0] rd_byte
);
  logic clr_stb;
  logic kick_stb;
  logic unused_bits;

  assign clr_stb     = wr_stb & wr_byte[B_CLR];
  assign kick_stb    = wr_stb & wr_byte[B_KICK];
  assign reload_evt  = kick_stb | (wr_stb & ~wr_byte[B_RUN]);
  assign unused_bits = ^{wr_byte[B_STAT], wr_byte[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_stb) begin
      ctrl_q <= take_ctrl(wr_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (tmo_evt) begin
      status_q <= 1'b1;
    end else if (clr_stb) begin
      status_q <= 1'b0;
    end
  end

  assign rd_byte = show_field(ctrl_q, status_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic reload_evt,
  output logic tmo_evt,
  output logic cnt_zero
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] FULL = CW'(PERIOD);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c,
                                             input logic run, input logic rld);
    if (rld)                return FULL;
    if (run && c != '0)     return c - ONE;
    return c;
  endfunction

  assign cnt_zero = (cnt_q == '0);
  assign tmo_evt  = run_en && (cnt_q == ONE) && !reload_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FULL;
    else        cnt_q <= next_cnt(cnt_q, run_en, reload_evt);
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sys_sel,
  output logic sys_rst_o,
  output logic loc_rst_o
);
  logic sys_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sys_q <= 1'b0;
    else if (start) sys_q <= sys_sel;
  end

  generate
    if (PULSE_LEN <= 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= start;
      end
      assign loc_rst_o = act_q;
    end else begin : g_count
      localparam int PW = $clog2(PULSE_LEN + 1);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               left_q <= '0;
        else if (start)           left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)    left_q <= left_q - PW'(1);
      end
      assign loc_rst_o = (left_q != '0);
    end
  endgenerate

  assign sys_rst_o = loc_rst_o & sys_q;
endmodule

// File: rtl/wdog_ctrl_top.sv
module wdog_ctrl_top
  import wdog_pkg::*;
#(
  parameter int PERIOD    = 1000,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sys_rst_o,
  output logic        loc_rst_o,
  output logic        board_fail_o
);
  wd_ctrl_t           ctrl_q;
  logic               status_q;
  logic               wr_stb;
  logic [FIELD_W-1:0] wr_byte;
  logic [FIELD_W-1:0] rd_byte;
  logic               reload_evt;
  logic               tmo_evt;
  logic               cnt_zero;
  logic               pulse_start;
  logic               run_en_w;
  logic               rst_en_w;
  logic               unused_wdata;

  assign wr_stb       = reg_sel & reg_wr;
  assign wr_byte      = reg_wdata[FIELD_LSB +: FIELD_W];
  assign unused_wdata = ^{reg_wdata[31:FIELD_LSB+FIELD_W], reg_wdata[FIELD_LSB-1:0]};
  assign run_en_w     = ctrl_q.run_en;
  assign rst_en_w     = ctrl_q.rst_en;
  assign pulse_start  = tmo_evt & rst_en_w;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .tmo_evt(tmo_evt), .ctrl_q(ctrl_q), .status_q(status_q),
    .reload_evt(reload_evt), .rd_byte(rd_byte)
  );

  wdog_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en_w), .reload_evt(reload_evt),
    .tmo_evt(tmo_evt), .cnt_zero(cnt_zero)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(pulse_start), .sys_sel(ctrl_q.sys_sel),
    .sys_rst_o(sys_rst_o), .loc_rst_o(loc_rst_o)
  );

  assign reg_rdata    = 32'(rd_byte) << FIELD_LSB;
  assign board_fail_o = status_q & ctrl_q.fail_en;
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        sys_rst_o,
  input logic        loc_rst_o,
  input logic        board_fail_o,
  input logic        tmo_evt,
  input logic        reload_evt,
  input logic        cnt_zero,
  input logic        run_en,
  input logic        rst_en
);
  assert_idle_no_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tmo_evt);
  assert_timeout_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> reg_rdata[21]);
  assert_kick_refills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> !cnt_zero);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[21] && !(reg_sel && reg_wr && reg_wdata[23])) |=> reg_rdata[21]);
  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !rst_en && !loc_rst_o) |=> !loc_rst_o);
  assert_pulse_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && rst_en) |=> loc_rst_o);
  assert_sys_has_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> loc_rst_o);
  assert_fail_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    board_fail_o |-> (reg_rdata[21] && reg_rdata[20]));
  assert_parked_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !reload_evt) |=> !tmo_evt);
endmodule

bind wdog_ctrl_top wdog_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_o(sys_rst_o),
  .loc_rst_o(loc_rst_o), .board_fail_o(board_fail_o), .tmo_evt(tmo_evt),
  .reload_evt(reload_evt), .cnt_zero(cnt_zero), .run_en(run_en_w),
  .rst_en(rst_en_w)
);

// File: tb/wdog_ctrl_top_tb.sv
`timescale 1ns/100ps
module wdog_ctrl_top_tb_top;
  localparam int P = 20;
  localparam int L = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_rst_o, loc_rst_o, board_fail_o;

  int checks = 0;
  int errors = 0;
  int loc_pulses = 0;
  int sys_pulses = 0;

  always #2.5 clk = ~clk;

  wdog_ctrl_top #(.PERIOD(P), .PULSE_LEN(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_o(sys_rst_o),
    .loc_rst_o(loc_rst_o), .board_fail_o(board_fail_o)
  );

  always @(posedge loc_rst_o) loc_pulses++;
  always @(posedge sys_rst_o) sys_pulses++;

  // behavioural reference model
  int  m_left = P;
  int  m_plen = 0;
  bit  m_psys = 0, m_stat = 0, m_run = 0, m_rste = 0, m_ssel = 0, m_fen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = P; m_plen = 0; m_psys = 0; m_stat = 0;
      m_run = 0; m_rste = 0; m_ssel = 0; m_fen = 0;
    end else begin
      automatic bit w      = reg_sel && reg_wr;
      automatic bit refill = w && (reg_wdata[22] || !reg_wdata[16]);
      automatic bit fire   = m_run && (m_left == 1) && !refill;
      if (refill) m_left = P;
      else if (m_run && m_left > 0) m_left = m_left - 1;
      if (fire && m_rste) begin m_plen = L; m_psys = m_ssel; end
      else if (m_plen > 0) m_plen = m_plen - 1;
      if (fire) m_stat = 1;
      else if (w && reg_wdata[23]) m_stat = 0;
      if (w) begin
        m_fen = reg_wdata[20]; m_ssel = reg_wdata[19];
        m_rste = reg_wdata[18]; m_run = reg_wdata[16];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [31:0] exp_rd = 32'({2'b00, m_stat, m_fen, m_ssel, m_rste, 1'b0, m_run}) << 16;
      chk(reg_rdata === exp_rd, "R2 model rdata", reg_rdata, exp_rd);
      chk(loc_rst_o === (m_plen > 0), "R8 model loc_rst", loc_rst_o, m_plen > 0);
      chk(sys_rst_o === (m_plen > 0 && m_psys), "R8 model sys_rst", sys_rst_o, m_plen > 0 && m_psys);
      chk(board_fail_o === (m_stat && m_fen), "R9 model board_fail", board_fail_o, m_stat && m_fen);
    end
  end

  task automatic wr(input logic [7:0] b);
    @(posedge clk); #1;
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'(b) << 16 | 32'hA5005A3C & 32'hFF00FFFF;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int lp;
    cyc(3); rst_n = 1; #1;
    // R1 reset state
    chk(reg_rdata === 32'h0, "R1 rdata", reg_rdata, 0);
    chk({sys_rst_o, loc_rst_o, board_fail_o} === 3'b000, "R1 outputs",
        {sys_rst_o, loc_rst_o, board_fail_o}, 0);

    // R2 readback, strobes/reserved/status not stored; R3 disabled
    wr(8'hFE);
    chk(reg_rdata === 32'h001C0000, "R2 readback", reg_rdata, 32'h001C0000);
    cyc(3*P);
    chk(reg_rdata[21] === 1'b0, "R3 no timeout while off", reg_rdata[21], 0);
    chk(loc_pulses == 0, "R3 no pulse while off", loc_pulses, 0);

    // R4 timing, R8 system pulse, R9 fail level
    wr(8'h1D);
    cyc(P-1);
    chk(reg_rdata[21] === 1'b0, "R4 not yet", reg_rdata[21], 0);
    cyc(1);
    chk(reg_rdata[21] === 1'b1, "R4 at period", reg_rdata[21], 1);
    chk(sys_rst_o === 1'b1 && loc_rst_o === 1'b1, "R8 sys+loc start", {sys_rst_o, loc_rst_o}, 3);
    chk(board_fail_o === 1'b1, "R9 fail on", board_fail_o, 1);
    cyc(L-1);
    chk(loc_rst_o === 1'b1, "R8 pulse held", loc_rst_o, 1);
    cyc(1);
    chk(loc_rst_o === 1'b0 && sys_rst_o === 1'b0, "R8 pulse end", {sys_rst_o, loc_rst_o}, 0);

    // R10 parked, R6 sticky and clear
    lp = loc_pulses;
    cyc(3*P);
    chk(loc_pulses == lp, "R10 single pulse", loc_pulses, lp);
    chk(reg_rdata[21] === 1'b1, "R6 sticky", reg_rdata[21], 1);
    wr(8'h9D);
    chk(reg_rdata[21] === 1'b0, "R6 cleared", reg_rdata[21], 0);
    chk(board_fail_o === 1'b0, "R9 fail off", board_fail_o, 0);
    cyc(2*P);
    chk(reg_rdata[21] === 1'b0, "R10 no retrigger", reg_rdata[21], 0);

    // R5 kicks, then local-only timeout
    wr(8'hC5);
    for (int k = 0; k < 5; k++) begin
      cyc(P-5);
      wr(8'h45);
    end
    chk(reg_rdata[21] === 1'b0, "R5 kicked in time", reg_rdata[21], 0);
    lp = sys_pulses;
    cyc(P);
    chk(loc_rst_o === 1'b1 && sys_rst_o === 1'b0, "R8 local only", {sys_rst_o, loc_rst_o}, 1);
    chk(board_fail_o === 1'b0, "R9 fail disabled", board_fail_o, 0);
    cyc(L+2);
    chk(sys_pulses == lp, "R8 no system pulse", sys_pulses, lp);

    // R7 reset disabled
    wr(8'hC1);
    lp = loc_pulses;
    cyc(P+5);
    chk(reg_rdata[21] === 1'b1, "R7 flag still set", reg_rdata[21], 1);
    chk(loc_pulses == lp, "R7 no pulse", loc_pulses, lp);

    // R6 set wins over clear on the same edge
    wr(8'hC5);
    cyc(P-1);
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h00850000;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0; reg_wdata = '0;
    chk(reg_rdata[21] === 1'b1, "R6 set beats clear", reg_rdata[21], 1);

    // R11 disabling write reloads
    wr(8'hC5);
    cyc(P/2);
    wr(8'h84);
    wr(8'h05);
    cyc(P-1);
    chk(reg_rdata[21] === 1'b0, "R11 full period restart", reg_rdata[21], 0);
    cyc(1);
    chk(reg_rdata[21] === 1'b1, "R11 timeout after reload", reg_rdata[21], 1);

    cyc(L+4);
    summary();
  end
endmodule